// File: doc/BRIEF.md
# Opcode Field Decoder

This block sits between the instruction fetch stage and the execute stage of an 8-bit accumulator CPU. Each opcode byte arrives with a one-cycle strobe. The block splits the byte into its fields: x in bits 7:6, y in bits 5:3, z in bits 2:0, p equal to y[2:1], and q equal to y[0]. Small index tables then turn those fields into register, register-pair and branch-condition selectors.

For every opcode the block reports the following:
- an operation class and a sub-operation index;
- destination and source register codes;
- a pair selector, a condition selector and an addressing mode;
- the instruction length in bytes, so that fetch can collect the immediates;
- the cycle count when a condition is false, and the count when it holds.

The byte 0xCB is reported as a prefix and not as an instruction. Opcodes with no assignment are flagged as illegal and decode as a NOP. All results come from a register and are updated only on a strobe.

Top module: `opcode_field_decoder`

## Requirements
- R1: A strobe sampled on a clock edge makes valid_o high and presents that opcode's decode from the same edge on. A cycle without a strobe drops valid_o on the following edge, and every decode output keeps its previous value.
- R2: Opcodes with x=1, except 0x76, decode as class 1 (register move), with dst_o=y and src_o=z. Register codes are B=0, C=1, D=2, E=3, H=4, L=5, memory at HL=6, A=7. Such an opcode is 1 byte long and takes 4 cycles, or 8 when either operand code is 6.
- R3: Opcode 0x76 decodes as class 13 (halt), 1 byte long, 4 cycles.
- R4: Opcodes with x=2 decode as class 5, with sub_op_o=y, src_o=z and dst_o=7. The sub_op_o codes are ADD=0, ADC=1, SUB=2, SBC=3, AND=4, XOR=5, OR=6, CP=7. These take 4 cycles, or 8 when z=6. Opcodes with x=3 and z=6 decode as class 6: the same sub-operation with an immediate source, dst_o=7, 2 bytes long, 8 cycles.
- R5: Pair codes are BC=0, DE=1, HL=2, SP=3, AF=4.
  - For LD pair,imm16 (class 3, 3 bytes, 12 cycles), ADD HL,pair (class 11, 8 cycles), 16-bit increment (class 9, 8 cycles) and 16-bit decrement (class 10, 8 cycles), p maps 0..3 to BC, DE, HL, SP.
  - For PUSH (class 20, 16 cycles) and POP (class 21, 12 cycles), p=3 maps to AF instead of SP.
- R6: Condition codes are NZ=0, Z=1, NC=2, C=3, always=4. Each conditional branch gives cyc_o for the not-taken case and cyc_t_o for the taken case:

  | Branch | Class | Condition | Length | Not taken / taken |
  |---|---|---|---|---|
  | JR | 15 | y-4 | 2 | 8 / 12 |
  | JP | 16 | y | 3 | 12 / 16 |
  | CALL | 17 | y | 3 | 12 / 24 |
  | RET | 18 | y | 1 | 8 / 20 |

  The unconditional forms have cond_o=4 and cyc_t_o equal to cyc_o: JR 12, JP imm16 16, CALL imm16 24, RET 16, and JP HL 4 with pair_o=HL.
- R7: NOP (0x00) is class 0 with 4 cycles. 8-bit increment (class 7) and 8-bit decrement (class 8) use dst_o=y and take 4 cycles, or 12 when y=6. Storing SP to an absolute address (0x08) is class 4 with store_o=1, pair_o=SP, amode_o=6, 3 bytes and 20 cycles.
- R8: Addressing mode codes are none=0, via pair=1, HL then increment=2, HL then decrement=3, 0xFF00 plus immediate=4, 0xFF00 plus C=5, absolute immediate=6. Memory moves are class 4; stores have store_o=1 and src_o=7, loads have store_o=0 and dst_o=7.
  - 0xE0 and 0xF0 use mode 4, 2 bytes, 12 cycles.
  - 0xE2 and 0xF2 use mode 5, 1 byte, 8 cycles.
  - 0xEA and 0xFA use mode 6, 3 bytes, 16 cycles.
- R9: Opcodes with x=0 and z=2 are class 4 with store_o equal to the inverse of q, 1 byte and 8 cycles.
  - p=0 and p=1 use amode_o=1 with pair BC or DE respectively.
  - p=2 uses amode_o=2 with pair HL; p=3 uses amode_o=3 with pair HL.
  - Register A is placed as stated in R8.
- R10: Byte 0xCB raises prefix_o, decodes as class 26, 2 bytes, 4 cycles, and illegal_o stays low.
- R11: The unassigned bytes 0xD3, 0xDB, 0xDD, 0xE3, 0xE4, 0xEB, 0xEC, 0xED, 0xF4, 0xFC and 0xFD raise illegal_o. Otherwise they decode exactly like NOP: class 0, 1 byte, 4 cycles.
- R12: The remaining classes decode as follows:

  | Instruction | Class | Fields | Length | Cycles |
  |---|---|---|---|---|
  | LD reg,imm8 | 2 | dst_o=y | 2 | 8, or 12 when y=6 |
  | RST | 22 | sub_op_o=y | 1 | 16 |
  | accumulator misc ops (x=0, z=7) | 12 | sub_op_o=y | 1 | 4 |
  | STOP | 14 | — | 2 | 4 |
  | ADD SP,d | 23 | pair SP | 2 | 16 |
  | LD HL,SP+d | 23 | pair HL | 2 | 12 |
  | LD SP,HL | 24 | pair SP | 1 | 8 |
  | DI / EI | 25 | sub_op_o=y | 1 | 4 |
  | return from interrupt | 19 | — | 1 | 16 |
- R13: Any field not named for an instruction reads 0, and cond_o reads 4 for instructions without a condition. After reset, valid_o is low and the outputs hold the NOP decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Opcode strobe |
| opcode_i | input | 8 | Opcode byte |
| valid_o | output | 1 | Decode presented this cycle |
| class_o | output | 5 | Operation class |
| sub_op_o | output | 3 | ALU, misc, RST or interrupt-control index |
| dst_o | output | 3 | Destination register code |
| src_o | output | 3 | Source register code |
| pair_o | output | 3 | Register pair code |
| cond_o | output | 3 | Condition code |
| amode_o | output | 3 | Memory addressing mode |
| store_o | output | 1 | Memory move writes memory |
| len_o | output | 2 | Instruction length in bytes |
| cyc_o | output | 5 | Base (not-taken) cycle count |
| cyc_t_o | output | 5 | Cycle count when the condition holds |
| prefix_o | output | 1 | Byte is the 0xCB prefix |
| illegal_o | output | 1 | Unassigned opcode |

## Verification
Every decode result is due one clock edge after the edge that samples its strobe, and valid_o rises on that same edge. The driver applies the strobe and opcode on a falling edge and pushes the expected decode into a queue. The monitor pops and compares it on the next falling edge whenever valid_o is high, so each result is read half a cycle after it settles. Idle stretches are checked on the falling edges that follow them: valid_o must be low and the last decode must still be present.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int OPC_W = 8;
  localparam int CLS_W = 5;
  localparam int SEL_W = 3;
  localparam int LEN_W = 2;
  localparam int CYC_W = 5;

  typedef enum logic [CLS_W-1:0] {
    OC_NOP = 5'd0, OC_LD8 = 5'd1, OC_LD8_IMM = 5'd2, OC_LD16_IMM = 5'd3,
    OC_LD_MEM = 5'd4, OC_ALU = 5'd5, OC_ALU_IMM = 5'd6, OC_INC8 = 5'd7,
    OC_DEC8 = 5'd8, OC_INC16 = 5'd9, OC_DEC16 = 5'd10, OC_ADD16 = 5'd11,
    OC_MISC = 5'd12, OC_HALT = 5'd13, OC_STOP = 5'd14, OC_JR = 5'd15,
    OC_JP = 5'd16, OC_CALL = 5'd17, OC_RET = 5'd18, OC_RETI = 5'd19,
    OC_PUSH = 5'd20, OC_POP = 5'd21, OC_RST = 5'd22, OC_SP_ADJ = 5'd23,
    OC_MOV16 = 5'd24, OC_INTCTL = 5'd25, OC_PREFIX = 5'd26
  } op_class_e;

  typedef enum logic [SEL_W-1:0] {
    PR_BC = 3'd0, PR_DE = 3'd1, PR_HL = 3'd2, PR_SP = 3'd3, PR_AF = 3'd4
  } pair_e;

  typedef enum logic [SEL_W-1:0] {
    CC_NZ = 3'd0, CC_Z = 3'd1, CC_NC = 3'd2, CC_C = 3'd3, CC_ALW = 3'd4
  } cond_e;

  typedef enum logic [SEL_W-1:0] {
    AM_NONE = 3'd0, AM_PAIR = 3'd1, AM_HLI = 3'd2, AM_HLD = 3'd3,
    AM_HIMM = 3'd4, AM_HC = 3'd5, AM_ABS = 3'd6
  } amode_e;

  localparam logic [SEL_W-1:0] REG_MHL = 3'd6;
  localparam logic [SEL_W-1:0] REG_A   = 3'd7;

  typedef struct packed {
    logic [1:0] x;
    logic [2:0] y;
    logic [2:0] z;
    logic [1:0] p;
    logic       q;
  } fld_t;

  typedef struct packed {
    op_class_e        cls;
    logic [SEL_W-1:0] sub;
    logic [SEL_W-1:0] dst;
    logic [SEL_W-1:0] src;
    pair_e            pair;
    cond_e            cond;
    amode_e           amode;
    logic             store;
    logic [LEN_W-1:0] len;
    logic [CYC_W-1:0] cyc;
    logic [CYC_W-1:0] cyc_t;
    logic             prefix;
    logic             illegal;
  } dec_t;

  // pair table used by loads and 16-bit arithmetic
  function automatic pair_e rp_lookup(input logic [1:0] idx);
    return pair_e'({1'b0, idx});
  endfunction

  // pair table used by push/pop: slot 3 is AF
  function automatic pair_e rp2_lookup(input logic [1:0] idx);
    return (idx == 2'd3) ? PR_AF : pair_e'({1'b0, idx});
  endfunction

  function automatic cond_e cc_lookup(input logic [1:0] idx);
    case (idx)
      2'd0:    return CC_NZ;
      2'd1:    return CC_Z;
      2'd2:    return CC_NC;
      default: return CC_C;
    endcase
  endfunction

  function automatic dec_t dec_default();
    dec_t d;
    d       = '0;
    d.cls   = OC_NOP;
    d.pair  = PR_BC;
    d.cond  = CC_ALW;
    d.amode = AM_NONE;
    d.len   = LEN_W'(1);
    d.cyc   = CYC_W'(4);
    d.cyc_t = CYC_W'(4);
    return d;
  endfunction
endpackage

// File: rtl/opdec_fields.sv
module opdec_fields
  import opdec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output fld_t             fld_o
);
  assign fld_o.x = opcode_i[7:6];
  assign fld_o.y = opcode_i[5:3];
  assign fld_o.z = opcode_i[2:0];
  assign fld_o.p = opcode_i[5:4];
  assign fld_o.q = opcode_i[3];
endmodule

// File: rtl/opdec_class.sv
module opdec_class
  import opdec_pkg::*;
(
  input  fld_t fld_i,
  output dec_t dec_o
);
  dec_t d;
  logic y_mem, z_mem;

  assign y_mem = (fld_i.y == REG_MHL);
  assign z_mem = (fld_i.z == REG_MHL);

  always_comb begin
    d = dec_default();
    unique case (fld_i.x)
      2'd0: begin
        unique case (fld_i.z)
          3'd0: begin
            case (fld_i.y)
              3'd0: ;
              3'd1: begin
                d.cls = OC_LD_MEM; d.store = 1'b1; d.pair = PR_SP;
                d.amode = AM_ABS; d.len = 2'd3; d.cyc = 5'd20;
              end
              3'd2: begin d.cls = OC_STOP; d.len = 2'd2; end
              3'd3: begin d.cls = OC_JR; d.len = 2'd2; d.cyc = 5'd12; end
              default: begin
                d.cls = OC_JR; d.len = 2'd2; d.cond = cc_lookup(fld_i.y[1:0]);
                d.cyc = 5'd8; d.cyc_t = 5'd12;
              end
            endcase
          end
          3'd1: begin
            d.pair = rp_lookup(fld_i.p);
            if (!fld_i.q) begin d.cls = OC_LD16_IMM; d.len = 2'd3; d.cyc = 5'd12; end
            else begin d.cls = OC_ADD16; d.cyc = 5'd8; end
          end
          3'd2: begin
            d.cls   = OC_LD_MEM;
            d.store = ~fld_i.q;
            d.cyc   = 5'd8;
            if (!fld_i.q) d.src = REG_A; else d.dst = REG_A;
            case (fld_i.p)
              2'd0:    begin d.amode = AM_PAIR; d.pair = PR_BC; end
              2'd1:    begin d.amode = AM_PAIR; d.pair = PR_DE; end
              2'd2:    begin d.amode = AM_HLI;  d.pair = PR_HL; end
              default: begin d.amode = AM_HLD;  d.pair = PR_HL; end
            endcase
          end
          3'd3: begin
            d.cls  = fld_i.q ? OC_DEC16 : OC_INC16;
            d.pair = rp_lookup(fld_i.p);
            d.cyc  = 5'd8;
          end
          3'd4, 3'd5: begin
            d.cls = (fld_i.z == 3'd4) ? OC_INC8 : OC_DEC8;
            d.dst = fld_i.y;
            d.cyc = y_mem ? 5'd12 : 5'd4;
          end
          3'd6: begin
            d.cls = OC_LD8_IMM; d.dst = fld_i.y; d.len = 2'd2;
            d.cyc = y_mem ? 5'd12 : 5'd8;
          end
          default: begin d.cls = OC_MISC; d.sub = fld_i.y; end
        endcase
      end
      2'd1: begin
        if (y_mem && z_mem) d.cls = OC_HALT;
        else begin
          d.cls = OC_LD8; d.dst = fld_i.y; d.src = fld_i.z;
          d.cyc = (y_mem || z_mem) ? 5'd8 : 5'd4;
        end
      end
      2'd2: begin
        d.cls = OC_ALU; d.sub = fld_i.y; d.src = fld_i.z; d.dst = REG_A;
        d.cyc = z_mem ? 5'd8 : 5'd4;
      end
      default: begin
        unique case (fld_i.z)
          3'd0: begin
            if (!fld_i.y[2]) begin
              d.cls = OC_RET; d.cond = cc_lookup(fld_i.y[1:0]);
              d.cyc = 5'd8; d.cyc_t = 5'd20;
            end else begin
              d.len = 2'd2;
              case (fld_i.y[1:0])
                2'd0: begin d.cls = OC_LD_MEM; d.store = 1'b1; d.src = REG_A; d.amode = AM_HIMM; d.cyc = 5'd12; end
                2'd1: begin d.cls = OC_SP_ADJ; d.pair = PR_SP; d.cyc = 5'd16; end
                2'd2: begin d.cls = OC_LD_MEM; d.dst = REG_A; d.amode = AM_HIMM; d.cyc = 5'd12; end
                default: begin d.cls = OC_SP_ADJ; d.pair = PR_HL; d.cyc = 5'd12; end
              endcase
            end
          end
          3'd1: begin
            if (!fld_i.q) begin
              d.cls = OC_POP; d.pair = rp2_lookup(fld_i.p); d.cyc = 5'd12;
            end else begin
              case (fld_i.p)
                2'd0:    begin d.cls = OC_RET;  d.cyc = 5'd16; end
                2'd1:    begin d.cls = OC_RETI; d.cyc = 5'd16; end
                2'd2:    begin d.cls = OC_JP;   d.pair = PR_HL; end
                default: begin d.cls = OC_MOV16; d.pair = PR_SP; d.cyc = 5'd8; end
              endcase
            end
          end
          3'd2: begin
            if (!fld_i.y[2]) begin
              d.cls = OC_JP; d.cond = cc_lookup(fld_i.y[1:0]); d.len = 2'd3;
              d.cyc = 5'd12; d.cyc_t = 5'd16;
            end else begin
              d.cls   = OC_LD_MEM;
              d.store = ~fld_i.y[1];
              if (!fld_i.y[1]) d.src = REG_A; else d.dst = REG_A;
              if (fld_i.y[0]) begin d.amode = AM_ABS; d.len = 2'd3; d.cyc = 5'd16; end
              else begin d.amode = AM_HC; d.cyc = 5'd8; end
            end
          end
          3'd3: begin
            case (fld_i.y)
              3'd0: begin d.cls = OC_JP; d.len = 2'd3; d.cyc = 5'd16; end
              3'd1: begin d.cls = OC_PREFIX; d.prefix = 1'b1; d.len = 2'd2; end
              3'd6, 3'd7: begin d.cls = OC_INTCTL; d.sub = fld_i.y; end
              default: d.illegal = 1'b1;
            endcase
          end
          3'd4: begin
            if (!fld_i.y[2]) begin
              d.cls = OC_CALL; d.cond = cc_lookup(fld_i.y[1:0]); d.len = 2'd3;
              d.cyc = 5'd12; d.cyc_t = 5'd24;
            end else d.illegal = 1'b1;
          end
          3'd5: begin
            if (!fld_i.q) begin
              d.cls = OC_PUSH; d.pair = rp2_lookup(fld_i.p); d.cyc = 5'd16;
            end else if (fld_i.p == 2'd0) begin
              d.cls = OC_CALL; d.len = 2'd3; d.cyc = 5'd24;
            end else d.illegal = 1'b1;
          end
          3'd6: begin
            d.cls = OC_ALU_IMM; d.sub = fld_i.y; d.dst = REG_A; d.len = 2'd2; d.cyc = 5'd8;
          end
          default: begin d.cls = OC_RST; d.sub = fld_i.y; d.cyc = 5'd16; end
        endcase
      end
    endcase
    if (d.cond == CC_ALW) d.cyc_t = d.cyc;
  end

  assign dec_o = d;
endmodule

// File: rtl/opdec_outreg.sv
module opdec_outreg
  import opdec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  dec_t dec_i,
  output logic valid_o,
  output dec_t dec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dec_o   <= dec_default();
    end else begin
      valid_o <= valid_i;
      if (valid_i) dec_o <= dec_i;
    end
  end
endmodule

// File: rtl/opcode_field_decoder.sv
module opcode_field_decoder
  import opdec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             valid_o,
  output logic [CLS_W-1:0] class_o,
  output logic [SEL_W-1:0] sub_op_o,
  output logic [SEL_W-1:0] dst_o,
  output logic [SEL_W-1:0] src_o,
  output logic [SEL_W-1:0] pair_o,
  output logic [SEL_W-1:0] cond_o,
  output logic [SEL_W-1:0] amode_o,
  output logic             store_o,
  output logic [LEN_W-1:0] len_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic [CYC_W-1:0] cyc_t_o,
  output logic             prefix_o,
  output logic             illegal_o
);
  fld_t fld;
  dec_t dec_c, dec_q;

  opdec_fields u_fields (.opcode_i(opcode_i), .fld_o(fld));
  opdec_class  u_class  (.fld_i(fld), .dec_o(dec_c));
  opdec_outreg u_oreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .dec_i(dec_c), .valid_o(valid_o), .dec_o(dec_q)
  );

  assign class_o   = dec_q.cls;
  assign sub_op_o  = dec_q.sub;
  assign dst_o     = dec_q.dst;
  assign src_o     = dec_q.src;
  assign pair_o    = dec_q.pair;
  assign cond_o    = dec_q.cond;
  assign amode_o   = dec_q.amode;
  assign store_o   = dec_q.store;
  assign len_o     = dec_q.len;
  assign cyc_o     = dec_q.cyc;
  assign cyc_t_o   = dec_q.cyc_t;
  assign prefix_o  = dec_q.prefix;
  assign illegal_o = dec_q.illegal;
endmodule

// File: rtl/opdec_checker.sv
module opdec_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [7:0] opcode_i,
  input logic       valid_o,
  input logic [4:0] class_o,
  input logic [2:0] dst_o,
  input logic [2:0] src_o,
  input logic [2:0] cond_o,
  input logic [1:0] len_o,
  input logic [4:0] cyc_o,
  input logic [4:0] cyc_t_o,
  input logic       prefix_o,
  input logic       illegal_o
);
  p_valid_next_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(class_o) && $stable(cyc_o) && $stable(len_o)));

  p_halt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == 8'h76) |=> (class_o == 5'd13));

  p_alu_ops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[7:6] == 2'd2) |=>
      (class_o == 5'd5 && dst_o == 3'd7 && src_o == $past(opcode_i[2:0])));

  p_uncond_equal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_o == 3'd4) |-> (cyc_t_o == cyc_o));

  p_taken_longer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_o != 3'd4) |-> (cyc_t_o > cyc_o));

  p_prefix_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == 8'hCB) |=> (prefix_o && !illegal_o && class_o == 5'd26));

  p_illegal_nop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (class_o == 5'd0 && len_o == 2'd1 && !prefix_o));
endmodule

bind opcode_field_decoder opdec_checker u_opdec_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opcode_i(opcode_i),
  .valid_o(valid_o), .class_o(class_o), .dst_o(dst_o), .src_o(src_o),
  .cond_o(cond_o), .len_o(len_o), .cyc_o(cyc_o), .cyc_t_o(cyc_t_o),
  .prefix_o(prefix_o), .illegal_o(illegal_o)
);

// File: tb/opcode_field_decoder_test.sv
module opcode_field_decoder_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] opcode_i = 8'h00;
  logic       valid_o, store_o, prefix_o, illegal_o;
  logic [4:0] class_o, cyc_o, cyc_t_o;
  logic [2:0] sub_op_o, dst_o, src_o, pair_o, cond_o, amode_o;
  logic [1:0] len_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [37:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  op_q[$];

  always #5 clk_i = ~clk_i;

  opcode_field_decoder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opcode_i(opcode_i),
    .valid_o(valid_o), .class_o(class_o), .sub_op_o(sub_op_o), .dst_o(dst_o),
    .src_o(src_o), .pair_o(pair_o), .cond_o(cond_o), .amode_o(amode_o),
    .store_o(store_o), .len_o(len_o), .cyc_o(cyc_o), .cyc_t_o(cyc_t_o),
    .prefix_o(prefix_o), .illegal_o(illegal_o)
  );

  wire [37:0] got = {class_o, sub_op_o, dst_o, src_o, pair_o, cond_o, amode_o,
                     store_o, len_o, cyc_o, cyc_t_o, prefix_o, illegal_o};

  function automatic logic [37:0] mk(
    input int cls, input int sub, input int dst, input int src, input int pair,
    input int cond, input int am, input int st, input int len, input int cyc,
    input int cyct, input int pre, input int ill);
    return {5'(cls), 3'(sub), 3'(dst), 3'(src), 3'(pair), 3'(cond), 3'(am),
            1'(st), 2'(len), 5'(cyc), 5'(cyct), 1'(pre), 1'(ill)};
  endfunction

  localparam logic [37:0] NOP_DEC = {5'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd4, 3'd0,
                                     1'b0, 2'd1, 5'd4, 5'd4, 1'b0, 1'b0};

  task automatic send(input logic [7:0] op, input logic [37:0] e, input string tag);
    @(negedge clk_i);
    valid_i  = 1'b1;
    opcode_i = op;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    op_q.push_back(op);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      opcode_i = ~opcode_i;
    end
  endtask

  task automatic check_now(input logic v, input logic [37:0] e, input string tag);
    checks++;
    if (valid_o !== v || got !== e) begin
      errors++;
      $display("FAIL %s: valid=%0b dec=%h expected valid=%0b dec=%h", tag, valid_o, got, v, e);
    end
  endtask

  // monitor: result is due one edge after the strobe; read on the falling edge
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1: unexpected valid_o, actual dec=%h expected none", got);
      end else begin
        logic [37:0] e;
        string t;
        logic [7:0] o;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        o = op_q.pop_front();
        if (got !== e) begin
          errors++;
          $display("FAIL %s op=%h: actual=%h expected=%h", t, o, got, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] bad[11] = '{8'hD3, 8'hDB, 8'hDD, 8'hE3, 8'hE4, 8'hEB,
                            8'hEC, 8'hED, 8'hF4, 8'hFC, 8'hFD};
    repeat (3) @(negedge clk_i);
    check_now(1'b0, NOP_DEC, "R13 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_now(1'b0, NOP_DEC, "R13 after reset");

    // cls sub dst src pair cond am st len cyc cyct pre ill
    send(8'h00, mk(0, 0, 0, 0, 0, 4, 0, 0, 1, 4, 4, 0, 0), "R7 nop");
    send(8'h08, mk(4, 0, 0, 0, 3, 4, 6, 1, 3, 20, 20, 0, 0), "R7 store sp");
    send(8'h3C, mk(7, 0, 7, 0, 0, 4, 0, 0, 1, 4, 4, 0, 0), "R7 inc a");
    send(8'h35, mk(8, 0, 6, 0, 0, 4, 0, 0, 1, 12, 12, 0, 0), "R7 dec (hl)");
    send(8'h41, mk(1, 0, 0, 1, 0, 4, 0, 0, 1, 4, 4, 0, 0), "R2 ld b,c");
    send(8'h7E, mk(1, 0, 7, 6, 0, 4, 0, 0, 1, 8, 8, 0, 0), "R2 ld a,(hl)");
    send(8'h70, mk(1, 0, 6, 0, 0, 4, 0, 0, 1, 8, 8, 0, 0), "R2 ld (hl),b");
    send(8'h76, mk(13, 0, 0, 0, 0, 4, 0, 0, 1, 4, 4, 0, 0), "R3 halt");
    send(8'h96, mk(5, 2, 7, 6, 0, 4, 0, 0, 1, 8, 8, 0, 0), "R4 sub (hl)");
    send(8'hA9, mk(5, 5, 7, 1, 0, 4, 0, 0, 1, 4, 4, 0, 0), "R4 xor c");
    send(8'hBF, mk(5, 7, 7, 7, 0, 4, 0, 0, 1, 4, 4, 0, 0), "R4 cp a");
    send(8'hFE, mk(6, 7, 7, 0, 0, 4, 0, 0, 2, 8, 8, 0, 0), "R4 cp imm");
    send(8'h01, mk(3, 0, 0, 0, 0, 4, 0, 0, 3, 12, 12, 0, 0), "R5 ld bc,nn");
    send(8'h31, mk(3, 0, 0, 0, 3, 4, 0, 0, 3, 12, 12, 0, 0), "R5 ld sp,nn");
    send(8'h29, mk(11, 0, 0, 0, 2, 4, 0, 0, 1, 8, 8, 0, 0), "R5 add hl,hl");
    send(8'h33, mk(9, 0, 0, 0, 3, 4, 0, 0, 1, 8, 8, 0, 0), "R5 inc sp");
    send(8'h0B, mk(10, 0, 0, 0, 0, 4, 0, 0, 1, 8, 8, 0, 0), "R5 dec bc");
    send(8'hF5, mk(20, 0, 0, 0, 4, 4, 0, 0, 1, 16, 16, 0, 0), "R5 push af");
    send(8'hC1, mk(21, 0, 0, 0, 0, 4, 0, 0, 1, 12, 12, 0, 0), "R5 pop bc");
    send(8'hF1, mk(21, 0, 0, 0, 4, 4, 0, 0, 1, 12, 12, 0, 0), "R5 pop af");
    send(8'h20, mk(15, 0, 0, 0, 0, 0, 0, 0, 2, 8, 12, 0, 0), "R6 jr nz");
    send(8'h38, mk(15, 0, 0, 0, 0, 3, 0, 0, 2, 8, 12, 0, 0), "R6 jr c");
    send(8'h18, mk(15, 0, 0, 0, 0, 4, 0, 0, 2, 12, 12, 0, 0), "R6 jr");
    send(8'hCA, mk(16, 0, 0, 0, 0, 1, 0, 0, 3, 12, 16, 0, 0), "R6 jp z");
    send(8'hC3, mk(16, 0, 0, 0, 0, 4, 0, 0, 3, 16, 16, 0, 0), "R6 jp nn");
    send(8'hE9, mk(16, 0, 0, 0, 2, 4, 0, 0, 1, 4, 4, 0, 0), "R6 jp hl");
    send(8'hC4, mk(17, 0, 0, 0, 0, 0, 0, 0, 3, 12, 24, 0, 0), "R6 call nz");
    send(8'hCD, mk(17, 0, 0, 0, 0, 4, 0, 0, 3, 24, 24, 0, 0), "R6 call nn");
    send(8'hD8, mk(18, 0, 0, 0, 0, 3, 0, 0, 1, 8, 20, 0, 0), "R6 ret c");
    send(8'hC9, mk(18, 0, 0, 0, 0, 4, 0, 0, 1, 16, 16, 0, 0), "R6 ret");
    send(8'hE0, mk(4, 0, 0, 7, 0, 4, 4, 1, 2, 12, 12, 0, 0), "R8 store high imm");
    send(8'hF0, mk(4, 0, 7, 0, 0, 4, 4, 0, 2, 12, 12, 0, 0), "R8 load high imm");
    send(8'hE2, mk(4, 0, 0, 7, 0, 4, 5, 1, 1, 8, 8, 0, 0), "R8 store high c");
    send(8'hF2, mk(4, 0, 7, 0, 0, 4, 5, 0, 1, 8, 8, 0, 0), "R8 load high c");
    send(8'hEA, mk(4, 0, 0, 7, 0, 4, 6, 1, 3, 16, 16, 0, 0), "R8 store abs");
    send(8'hFA, mk(4, 0, 7, 0, 0, 4, 6, 0, 3, 16, 16, 0, 0), "R8 load abs");
    idle(2);
    @(negedge clk_i);
    check_now(1'b0, mk(4, 0, 7, 0, 0, 4, 6, 0, 3, 16, 16, 0, 0), "R1 hold after idle");
    send(8'h02, mk(4, 0, 0, 7, 0, 4, 1, 1, 1, 8, 8, 0, 0), "R9 ld (bc),a");
    send(8'h1A, mk(4, 0, 7, 0, 1, 4, 1, 0, 1, 8, 8, 0, 0), "R9 ld a,(de)");
    send(8'h22, mk(4, 0, 0, 7, 2, 4, 2, 1, 1, 8, 8, 0, 0), "R9 ld (hl+),a");
    send(8'h3A, mk(4, 0, 7, 0, 2, 4, 3, 0, 1, 8, 8, 0, 0), "R9 ld a,(hl-)");
    send(8'hCB, mk(26, 0, 0, 0, 0, 4, 0, 0, 2, 4, 4, 1, 0), "R10 prefix");
    for (int i = 0; i < 11; i++)
      send(bad[i], mk(0, 0, 0, 0, 0, 4, 0, 0, 1, 4, 4, 0, 1), "R11 illegal");
    send(8'h06, mk(2, 0, 0, 0, 0, 4, 0, 0, 2, 8, 8, 0, 0), "R12 ld b,n");
    send(8'h36, mk(2, 0, 6, 0, 0, 4, 0, 0, 2, 12, 12, 0, 0), "R12 ld (hl),n");
    send(8'hFF, mk(22, 7, 0, 0, 0, 4, 0, 0, 1, 16, 16, 0, 0), "R12 rst");
    send(8'h07, mk(12, 0, 0, 0, 0, 4, 0, 0, 1, 4, 4, 0, 0), "R12 misc 0");
    send(8'h2F, mk(12, 5, 0, 0, 0, 4, 0, 0, 1, 4, 4, 0, 0), "R12 misc 5");
    send(8'h10, mk(14, 0, 0, 0, 0, 4, 0, 0, 2, 4, 4, 0, 0), "R12 stop");
    send(8'hE8, mk(23, 0, 0, 0, 3, 4, 0, 0, 2, 16, 16, 0, 0), "R12 add sp,d");
    send(8'hF8, mk(23, 0, 0, 0, 2, 4, 0, 0, 2, 12, 12, 0, 0), "R12 ld hl,sp+d");
    send(8'hF9, mk(24, 0, 0, 0, 3, 4, 0, 0, 1, 8, 8, 0, 0), "R12 ld sp,hl");
    send(8'hF3, mk(25, 6, 0, 0, 0, 4, 0, 0, 1, 4, 4, 0, 0), "R12 di");
    send(8'hD9, mk(19, 0, 0, 0, 0, 4, 0, 0, 1, 16, 16, 0, 0), "R12 reti");
    send(8'h00, NOP_DEC, "R13 nop defaults");
    idle(3);
    check_now(1'b0, NOP_DEC, "R1 idle keeps last");
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d results missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule